// File: doc/BRIEF.md
# Workspace-Windowed Register File

This block keeps a processor's general registers in a small on-chip RAM instead of flip-flops. A workspace pointer gives the RAM base of the active window of sixteen words. Every register number the core presents is added to that pointer, modulo the RAM depth, to form a RAM address. The block has two read ports and one write port. Reads return data one clock after an accepted request. A write and a read of the same location in the same cycle return the newly written value.

Moving the pointer is cheap, so the register window can serve as a stack frame. A signed adjust op slides the window up or down without copying any data. A context-switch op moves the window by a signed offset from the current pointer. It then stores the old pointer, the core's program counter and its status into the top three slots of the new window, one word per cycle. A return op reads those three slots back and restores the pointer, program counter and status. A link op stores the return address in a fixed slot and leaves the pointer where it is.

Top module: `wsreg_file`

## Requirements
- R1: After reset, wp is 0 and busy, ovf, rd_valid, pc_out and st_out are all 0.
- R2: A read is accepted when rd_req is 1, busy is 0 and no return op is accepted in the same cycle. One cycle after an accepted read, rd_valid is 1 and rd_a_data/rd_b_data hold the words at RAM address (wp + index) mod depth.
- R3: A write is accepted when wr_en is 1, busy is 0 and no link op is accepted in the same cycle. It stores wr_data at (wp + wr_idx) mod depth. A read of the same location accepted in the same cycle returns the new value.
- R4: op_code 4 (adjust) sets wp to (wp + sign-extended op_off) mod depth at the next edge. busy stays 0, and the RAM contents are untouched.
- R5: op_code 1 (switch) sets wp to (wp + signed op_off) mod depth at the next edge. busy is then 1 for exactly three cycles. Slots 13, 14 and 15 of the new window receive, in that order, the old wp (zero-extended), and the pc_in and st_in sampled when the op was accepted.
- R6: op_code 2 (return) holds busy at 1 for exactly two cycles. It then loads wp from slot 13, pc_out from slot 14 and st_out from slot 15 of the window that was active when the op was accepted.
- R7: op_code 3 (link) writes pc_in to slot 11 of the current window. wp is unchanged, busy stays 0, and a register-port write in the same cycle is dropped.
- R8: While busy is 1, register-port reads, writes and ops are ignored. rd_valid is 0 in the cycle after any busy cycle.
- R9: ovf is 1 exactly when the current window runs past the top of the RAM, that is when wp > depth - 16.
- R10: Window addresses and pointer arithmetic wrap modulo the RAM depth, so the upper slots of a window near the top map to the lowest RAM words.
- R11: op_code values 0, 5, 6 and 7 change neither wp, the RAM, pc_out, st_out nor busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read request for both read ports |
| rd_a_idx | input | IDX_W | Register number for read port A |
| rd_b_idx | input | IDX_W | Register number for read port B |
| rd_a_data | output | DW | Read data, port A |
| rd_b_data | output | DW | Read data, port B |
| rd_valid | output | 1 | Read data belongs to an accepted request |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Register number to write |
| wr_data | input | DW | Write data |
| op_valid | input | 1 | Pointer operation request |
| op_code | input | 3 | 1 switch, 2 return, 3 link, 4 adjust |
| op_off | input | OFF_W | Signed pointer offset for switch and adjust |
| pc_in | input | DW | Program counter from the core |
| st_in | input | DW | Status word from the core |
| wp | output | AW | Current workspace pointer |
| pc_out | output | DW | Program counter restored by return |
| st_out | output | DW | Status restored by return |
| busy | output | 1 | Multi-cycle operation in progress |
| ovf | output | 1 | Current window crosses the top of the RAM |

## Verification
The assertions assume the core drops its port requests and ops while busy is high. They also assume that op_off stays within the signed range of OFF_W bits, so a window step never exceeds what the field encodes. The bench keeps to both assumptions on every check except the stall cycles of the switch test. There it drives writes, reads and an adjust on purpose into a busy window. It then confirms at the ports that none of them took effect. The bench also enters no link op together with a same-cycle read of slot 11, so the bypass assertion only ever sees register-port writes.

// File: rtl/wsr_pkg.sv
`timescale 1ns/1ps
package wsr_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_SWITCH = 3'd1,
    OP_RETURN = 3'd2,
    OP_LINK   = 3'd3,
    OP_ADJUST = 3'd4
  } wsr_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE_WP,
    ST_SAVE_PC,
    ST_SAVE_ST,
    ST_LOAD1,
    ST_LOAD2
  } wsr_state_e;

endpackage

// File: rtl/wsr_ram.sv
`timescale 1ns/1ps
module wsr_ram #(
  parameter int AW  = 6,
  parameter int DW  = 16,
  parameter int NRD = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read ports; a same-cycle write to the same word wins
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic hit;
    assign hit = we && (waddr == raddr[p]);
    always_ff @(posedge clk) begin
      rq[p] <= hit ? wdata : mem[raddr[p]];
    end
  end
endmodule

// File: rtl/wsr_ptr.sv
`timescale 1ns/1ps
module wsr_ptr #(
  parameter int AW     = 6,
  parameter int IDX_W  = 4,
  parameter int WP_RST = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] wp,
  output logic          ovf
);
  localparam int DEPTH = 1 << AW;
  localparam int WIN   = 1 << IDX_W;
  localparam logic [AW-1:0] LIMIT = AW'(DEPTH - WIN);

  function automatic logic crosses_top(input logic [AW-1:0] base);
    return base > LIMIT;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= AW'(WP_RST);
      ovf <= crosses_top(AW'(WP_RST));
    end else if (ld) begin
      wp  <= nxt;
      ovf <= crosses_top(nxt);
    end
  end
endmodule

// File: rtl/wsr_seq.sv
`timescale 1ns/1ps
module wsr_seq
  import wsr_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int OFF_W = 6,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [OFF_W-1:0] op_off,
  input  logic [DW-1:0]    pc_in,
  input  logic [DW-1:0]    st_in,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] rd_b_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    wp,
  input  logic [DW-1:0]    q_a,
  input  logic [DW-1:0]    q_b,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic [DW-1:0]    ram_wdata,
  output logic [AW-1:0]    ram_ra,
  output logic [AW-1:0]    ram_rb,
  output logic             wp_ld,
  output logic [AW-1:0]    wp_nxt,
  output logic [DW-1:0]    pc_out,
  output logic [DW-1:0]    st_out,
  output logic             busy,
  output logic             rd_valid,
  output logic             acc_rd,
  output logic             acc_wr,
  output logic             acc_op
);
  localparam int WIN = 1 << IDX_W;
  localparam logic [IDX_W-1:0] SLOT_ST   = IDX_W'(WIN - 1);
  localparam logic [IDX_W-1:0] SLOT_PC   = IDX_W'(WIN - 2);
  localparam logic [IDX_W-1:0] SLOT_WP   = IDX_W'(WIN - 3);
  localparam logic [IDX_W-1:0] SLOT_LINK = IDX_W'(WIN - 5);

  function automatic logic [AW-1:0] win_addr(input logic [AW-1:0] base,
                                             input logic [IDX_W-1:0] idx);
    return base + AW'(idx);
  endfunction

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] base,
                                             input logic [OFF_W-1:0] off);
    return base + AW'($signed(off));
  endfunction

  wsr_state_e state_q, state_d;
  logic [AW-1:0] sv_wp_q;
  logic [DW-1:0] sv_pc_q, sv_st_q;
  logic is_sw, is_ret, is_lnk, is_adj;

  assign busy   = (state_q != ST_IDLE);
  assign acc_op = op_valid && !busy;
  assign is_sw  = acc_op && (op_code == OP_SWITCH);
  assign is_ret = acc_op && (op_code == OP_RETURN);
  assign is_lnk = acc_op && (op_code == OP_LINK);
  assign is_adj = acc_op && (op_code == OP_ADJUST);
  assign acc_rd = rd_req && !busy && !is_ret;
  assign acc_wr = wr_en && !busy && !is_lnk;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (is_sw)       state_d = ST_SAVE_WP;
        else if (is_ret) state_d = ST_LOAD1;
      end
      ST_SAVE_WP: state_d = ST_SAVE_PC;
      ST_SAVE_PC: state_d = ST_SAVE_ST;
      ST_SAVE_ST: state_d = ST_IDLE;
      ST_LOAD1:   state_d = ST_LOAD2;
      ST_LOAD2:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // read address steering: return borrows both ports
  always_comb begin
    ram_ra = win_addr(wp, rd_a_idx);
    ram_rb = win_addr(wp, rd_b_idx);
    if (is_ret) begin
      ram_ra = win_addr(wp, SLOT_WP);
      ram_rb = win_addr(wp, SLOT_PC);
    end else if (state_q == ST_LOAD1) begin
      ram_ra = win_addr(wp, SLOT_ST);
    end
  end

  // write steering: save sequence, then link, then register port
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = win_addr(wp, wr_idx);
    ram_wdata = wr_data;
    case (state_q)
      ST_SAVE_WP: begin
        ram_we    = 1'b1;
        ram_waddr = win_addr(wp, SLOT_WP);
        ram_wdata = DW'(sv_wp_q);
      end
      ST_SAVE_PC: begin
        ram_we    = 1'b1;
        ram_waddr = win_addr(wp, SLOT_PC);
        ram_wdata = sv_pc_q;
      end
      ST_SAVE_ST: begin
        ram_we    = 1'b1;
        ram_waddr = win_addr(wp, SLOT_ST);
        ram_wdata = sv_st_q;
      end
      default: begin
        if (is_lnk) begin
          ram_we    = 1'b1;
          ram_waddr = win_addr(wp, SLOT_LINK);
          ram_wdata = pc_in;
        end else if (acc_wr) begin
          ram_we = 1'b1;
        end
      end
    endcase
  end

  assign wp_ld  = is_sw || is_adj || (state_q == ST_LOAD2);
  assign wp_nxt = (state_q == ST_LOAD2) ? sv_wp_q : ptr_step(wp, op_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sv_wp_q  <= '0;
      sv_pc_q  <= '0;
      sv_st_q  <= '0;
      pc_out   <= '0;
      st_out   <= '0;
      rd_valid <= 1'b0;
    end else begin
      state_q  <= state_d;
      rd_valid <= acc_rd;
      if (is_sw) begin
        sv_wp_q <= wp;
        sv_pc_q <= pc_in;
        sv_st_q <= st_in;
      end
      if (state_q == ST_LOAD1) begin
        sv_wp_q <= q_a[AW-1:0];
        sv_pc_q <= q_b;
      end
      if (state_q == ST_LOAD2) begin
        pc_out <= sv_pc_q;
        st_out <= q_a;
      end
    end
  end
endmodule

// File: rtl/wsreg_file.sv
`timescale 1ns/1ps
module wsreg_file #(
  parameter int AW     = 6,
  parameter int DW     = 16,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 4,
  parameter int WP_RST = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]    rd_a_data,
  output logic [DW-1:0]    rd_b_data,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [OFF_W-1:0] op_off,
  input  logic [DW-1:0]    pc_in,
  input  logic [DW-1:0]    st_in,
  output logic [AW-1:0]    wp,
  output logic [DW-1:0]    pc_out,
  output logic [DW-1:0]    st_out,
  output logic             busy,
  output logic             ovf
);
  // internal events brought out for the checker
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [DW-1:0] ram_wdata;
  logic [AW-1:0] ram_ra, ram_rb;
  logic [DW-1:0] q_a, q_b;
  logic          wp_ld;
  logic [AW-1:0] wp_nxt;
  logic          acc_rd, acc_wr, acc_op;
  logic [1:0][AW-1:0] raddr_bus;
  logic [1:0][DW-1:0] rq_bus;

  assign raddr_bus = {ram_rb, ram_ra};
  assign q_a       = rq_bus[0];
  assign q_b       = rq_bus[1];
  assign rd_a_data = q_a;
  assign rd_b_data = q_b;

  wsr_ram #(.AW(AW), .DW(DW), .NRD(2)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (raddr_bus),
    .rq    (rq_bus)
  );

  wsr_ptr #(.AW(AW), .IDX_W(IDX_W), .WP_RST(WP_RST)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (wp_ld),
    .nxt   (wp_nxt),
    .wp    (wp),
    .ovf   (ovf)
  );

  wsr_seq #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_off    (op_off),
    .pc_in     (pc_in),
    .st_in     (st_in),
    .rd_req    (rd_req),
    .rd_a_idx  (rd_a_idx),
    .rd_b_idx  (rd_b_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .wp        (wp),
    .q_a       (q_a),
    .q_b       (q_b),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .ram_ra    (ram_ra),
    .ram_rb    (ram_rb),
    .wp_ld     (wp_ld),
    .wp_nxt    (wp_nxt),
    .pc_out    (pc_out),
    .st_out    (st_out),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_op    (acc_op)
  );
endmodule

// File: rtl/wsreg_chk.sv
`timescale 1ns/1ps
module wsreg_chk
  import wsr_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int OFF_W = 6,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             rd_valid,
  input logic [AW-1:0]    wp,
  input logic             ovf,
  input logic             acc_op,
  input logic [2:0]       op_code,
  input logic [OFF_W-1:0] op_off,
  input logic             acc_rd,
  input logic             acc_wr,
  input logic             ram_we,
  input logic [AW-1:0]    ram_waddr,
  input logic [IDX_W-1:0] rd_a_idx,
  input logic [IDX_W-1:0] wr_idx,
  input logic [DW-1:0]    wr_data,
  input logic [DW-1:0]    rd_a_data
);
  localparam int DEPTH = 1 << AW;
  localparam int WIN   = 1 << IDX_W;
  localparam logic [AW-1:0] LIMIT   = AW'(DEPTH - WIN);
  localparam logic [AW-1:0] SLOT_LO = AW'(WIN - 3);

  logic [2:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 3'd1;
    else           busy_run <= '0;
  end

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < 3'd3));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rd_valid);

  p_save_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && busy) |-> (AW'(ram_waddr - wp) >= SLOT_LO));

  p_link_keeps_wp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_op && op_code == OP_LINK) |=> (wp == $past(wp)) && !busy);

  p_adjust_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_op && op_code == OP_ADJUST) |=>
      (wp == $past(wp) + AW'($signed($past(op_off)))) && !busy);

  p_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_op && op_code == OP_SWITCH) |=>
      (wp == $past(wp) + AW'($signed($past(op_off)))) && busy);

  p_return_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_op && op_code == OP_RETURN) |=> busy && $stable(wp));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf == (wp > LIMIT));

  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_rd && wr_idx == rd_a_idx) |=> rd_a_data == $past(wr_data));
endmodule

bind wsreg_file wsreg_chk #(.AW(AW), .DW(DW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .wp        (wp),
  .ovf       (ovf),
  .acc_op    (acc_op),
  .op_code   (op_code),
  .op_off    (op_off),
  .acc_rd    (acc_rd),
  .acc_wr    (acc_wr),
  .ram_we    (ram_we),
  .ram_waddr (ram_waddr),
  .rd_a_idx  (rd_a_idx),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .rd_a_data (rd_a_data)
);

// File: tb/tb_wsreg_file.sv
`timescale 1ns/1ps
module tb_wsreg_file;
  localparam int DEP = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0;
  logic [15:0] rd_a_data, rd_b_data;
  logic        rd_valid;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [5:0]  op_off = '0;
  logic [15:0] pc_in = '0, st_in = '0;
  logic [5:0]  wp;
  logic [15:0] pc_out, st_out;
  logic        busy, ovf;

  int n_chk = 0;
  int n_err = 0;
  int mwp = 0;
  logic [15:0] model [DEP];

  always #2.5 clk = ~clk;

  wsreg_file dut (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_valid(rd_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .op_valid(op_valid), .op_code(op_code), .op_off(op_off),
    .pc_in(pc_in), .st_in(st_in),
    .wp(wp), .pc_out(pc_out), .st_out(st_out), .busy(busy), .ovf(ovf)
  );

  function automatic int ad(int base, int idx);
    return (base + idx) % DEP;
  endfunction

  function automatic logic [15:0] pat(int a);
    return 16'((a * 881) ^ 16'h5A00);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    rd_req = 1'b0; wr_en = 1'b0; op_valid = 1'b0;
  endtask

  task automatic edge_sample();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(int idx, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
    edge_sample();
    clear_in();
    model[ad(mwp, idx)] = d;
  endtask

  task automatic do_read(int a, int b, output logic [15:0] da,
                         output logic [15:0] db, output logic v);
    @(negedge clk);
    rd_req = 1'b1; rd_a_idx = 4'(a); rd_b_idx = 4'(b);
    edge_sample();
    da = rd_a_data; db = rd_b_data; v = rd_valid;
    clear_in();
  endtask

  task automatic do_op(int code, int off);
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'(code); op_off = 6'(off);
    edge_sample();
    clear_in();
  endtask

  task automatic read_chk(string tag, int a, int b);
    logic [15:0] da, db;
    logic v;
    do_read(a, b, da, db, v);
    check(tag, {31'd0, v}, 32'd1);
    check(tag, {16'd0, da}, {16'd0, model[ad(mwp, a)]});
    check(tag, {16'd0, db}, {16'd0, model[ad(mwp, b)]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] da, db;
    logic v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 wp", {26'd0, wp}, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 ovf", {31'd0, ovf}, 32'd0);
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1 pc_out", {16'd0, pc_out}, 32'd0);
    check("R1 st_out", {16'd0, st_out}, 32'd0);

    // fill the whole RAM window by window (R3, R4, R10)
    for (int blk = 0; blk < 4; blk++) begin
      for (int i = 0; i < 16; i++) do_write(i, pat(ad(mwp, i)));
      do_op(4, 16);
      mwp = (mwp + 16) % DEP;
      check("R4 adjust wp", {26'd0, wp}, 32'(mwp));
    end
    check("R10 wp wraps to 0", {26'd0, wp}, 32'd0);

    // sweep every pointer value, every register index (R2, R9, R10)
    for (int w = 0; w < DEP; w++) begin
      check("R9 ovf", {31'd0, ovf}, {31'd0, (w > DEP - 16)});
      for (int i = 0; i < 16; i++)
        read_chk((w + i >= DEP) ? "R10 wrapped read" : "R2 read", i, 15 - i);
      do_op(4, 1);
      mwp = (mwp + 1) % DEP;
    end

    // R3 same-cycle write/read bypass
    for (int i = 0; i < 16; i += 5) begin
      logic [15:0] nv;
      nv = 16'hC000 + 16'(i);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'(i); wr_data = nv;
      rd_req = 1'b1; rd_a_idx = 4'(i); rd_b_idx = 4'((i + 1) % 16);
      edge_sample();
      clear_in();
      model[ad(mwp, i)] = nv;
      check("R3 bypass port A", {16'd0, rd_a_data}, {16'd0, nv});
      check("R3 other port B", {16'd0, rd_b_data}, {16'd0, model[ad(mwp, (i + 1) % 16)]});
      read_chk("R3 stored", i, i);
    end

    // R4 negative adjust, no data copy
    do_op(4, -5);
    mwp = (mwp + DEP - 5) % DEP;
    check("R4 neg adjust wp", {26'd0, wp}, 32'(mwp));
    check("R4 busy low", {31'd0, busy}, 32'd0);
    check("R9 ovf high", {31'd0, ovf}, 32'd1);
    read_chk("R4 window slid", 5, 0);

    // R11 undefined / nop codes
    do_op(5, 7); do_op(0, 3); do_op(6, 2); do_op(7, 1);
    check("R11 wp", {26'd0, wp}, 32'(mwp));
    check("R11 busy", {31'd0, busy}, 32'd0);
    check("R11 pc_out", {16'd0, pc_out}, 32'd0);
    read_chk("R11 ram", 13, 15);

    // R7 link with a colliding register write
    @(negedge clk);
    pc_in = 16'hBEEF;
    op_valid = 1'b1; op_code = 3'd3; op_off = 6'd9;
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 16'h1111;
    edge_sample();
    clear_in();
    model[ad(mwp, 11)] = 16'hBEEF;
    check("R7 wp unchanged", {26'd0, wp}, 32'(mwp));
    check("R7 busy low", {31'd0, busy}, 32'd0);
    read_chk("R7 slot11 / dropped write", 11, 3);

    // move to wp 8 then switch by +20 (R5, R8)
    do_op(4, (8 - mwp + DEP) % DEP > 31 ? (8 - mwp) : (8 - mwp + DEP) % DEP);
    mwp = 8;
    check("R4 to 8", {26'd0, wp}, 32'd8);
    @(negedge clk);
    pc_in = 16'h1234; st_in = 16'h00A5;
    op_valid = 1'b1; op_code = 3'd1; op_off = 6'd20;
    edge_sample();
    clear_in();
    pc_in = 16'h0; st_in = 16'h0;
    check("R5 new wp", {26'd0, wp}, 32'd28);
    check("R5 busy 1", {31'd0, busy}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'd0; wr_data = 16'hDEAD;
      rd_req = 1'b1; rd_a_idx = 4'd1; rd_b_idx = 4'd2;
      op_valid = 1'b1; op_code = 3'd4; op_off = 6'd1;
      edge_sample();
      clear_in();
      check("R5 busy length", {31'd0, busy}, {31'd0, (k < 2)});
      check("R8 rd_valid low", {31'd0, rd_valid}, 32'd0);
    end
    mwp = 28;
    check("R8 op ignored", {26'd0, wp}, 32'd28);
    check("R9 ovf low", {31'd0, ovf}, 32'd0);
    model[ad(28, 13)] = 16'd8;
    model[ad(28, 14)] = 16'h1234;
    model[ad(28, 15)] = 16'h00A5;
    read_chk("R5 saved wp/pc", 13, 14);
    read_chk("R5 saved st / R8 write ignored", 15, 0);

    // R6 return
    do_op(2, 0);
    check("R6 busy 1", {31'd0, busy}, 32'd1);
    edge_sample();
    check("R6 busy 2", {31'd0, busy}, 32'd1);
    edge_sample();
    check("R6 busy done", {31'd0, busy}, 32'd0);
    check("R6 wp", {26'd0, wp}, 32'd8);
    check("R6 pc_out", {16'd0, pc_out}, 32'h1234);
    check("R6 st_out", {16'd0, st_out}, 32'h00A5);
    mwp = 8;

    // switch across the top of the RAM (R10, R9)
    do_op(4, 31); do_op(4, 21);
    mwp = 60;
    check("R9 ovf at 60", {31'd0, ovf}, 32'd1);
    @(negedge clk);
    pc_in = 16'h0F0F; st_in = 16'h0033;
    op_valid = 1'b1; op_code = 3'd1; op_off = 6'd10;
    edge_sample();
    clear_in();
    edge_sample(); edge_sample(); edge_sample();
    check("R10 switch wraps", {26'd0, wp}, 32'd6);
    check("R9 ovf after wrap", {31'd0, ovf}, 32'd0);
    mwp = 6;
    model[19] = 16'd60; model[20] = 16'h0F0F; model[21] = 16'h0033;
    read_chk("R10 saved slots", 13, 14);
    read_chk("R10 saved st", 15, 15);
    do_op(2, 0);
    edge_sample(); edge_sample();
    check("R6 wp restore 60", {26'd0, wp}, 32'd60);
    check("R6 ovf restore", {31'd0, ovf}, 32'd1);
    check("R6 pc 0F0F", {16'd0, pc_out}, 32'h0F0F);
    mwp = 60;
    read_chk("R10 old window intact", 2, 9);

    // negative switch offset
    @(negedge clk);
    pc_in = 16'h7777; st_in = 16'h0001;
    op_valid = 1'b1; op_code = 3'd1; op_off = 6'(-20);
    edge_sample();
    clear_in();
    edge_sample(); edge_sample(); edge_sample();
    check("R5 negative switch wp", {26'd0, wp}, 32'd40);
    mwp = 40;
    model[53] = 16'd60; model[54] = 16'h7777; model[55] = 16'h0001;
    read_chk("R5 negative switch slots", 13, 14);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule